// File: doc/BRIEF.md
# Three-Wire Control Register Interface

This block is the configuration front end of a radio transceiver's control logic. It accepts a clock line, a data line and an enable line from an external host. Bits are collected in a 24-bit shift register. When the enable line goes high, the two top bits pick one of four 22-bit control words, and the low 22 bits are written into that word. The four words and an operating-state code are the block's outputs and feed the synthesizer and the radio sections.

The same pins have a second use at start-up. The part comes out of reset in a strapped, fixed-channel mode. Two strap inputs pick one of four preset channels, and the fixed mode fills all four words with that channel's divider ratios. The serial clock and data pins act as receive-enable and transmit-enable inputs and choose the operating state. The first level change on the enable/strap pin moves the block into programmable mode for good. From then on only serial writes alter the words, and the second strap pin becomes a lock-detect output. All pins are brought into the system clock through two-flop synchronizers. Edges are detected on the synchronized copies, so every pin event takes effect three clock edges after it reaches the pin.

Top module: `cfg3w_port`

## Requirements
- R1: Each rising edge of the serial clock shifts the data pin into the 24-bit shift register, most significant bit first. When more than 24 bits are sent, only the last 24 are kept.
- R2: A rising edge of the enable pin copies shift bits 21:0 into the word selected by shift bits 23:22 (00 = word A, 01 = word B, 10 = word C, 11 = word D).
- R3: A write updates only the addressed word. The other three keep their contents.
- R4: After reset the block is in fixed mode: prog_mode_o = 0, lock_oe_o = 0 and lock_o = 0.
- R5: In fixed mode the strap pair (strap0 = enable pin, strap1) loads the preset channel. The layout is: A[9:0] and B[9:0] = reference ratio, C[16:0] = receive feedback ratio, C[17] = high band, D[16:0] = transmit feedback ratio, and all other bits 0. (strap0,strap1) = (1,0) gives 16/947/971/band 0. (0,0) gives 16/1919/1943/band 1. (1,1) gives 18/766/793/band 0. (0,1) gives 30/3794/3839/band 1.
- R6: In fixed mode the serial clock pin acts as RE and the data pin as TE. op_mode_o = {TE,RE}: 00 standby, 01 receive, 10 transmit, 11 idle. A[11:10] carries the same {TE,RE} value.
- R7: In programmable mode op_mode_o equals A[11:10], using the same code.
- R8: Once the pins have settled after reset, the first level change on the enable pin (rising or falling) sets programmable mode, and it stays set until reset. The words keep the preset of the strap levels that held before that change. If the change is a rising edge, it also performs the R2 write.
- R9: In programmable mode, changes on strap1 and on the mode pins do not alter any word.
- R10: In programmable mode lock_oe_o = 1 and lock_o follows lock_in_i. In fixed mode both are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pin_clk_mode0_i | input | 1 | Serial clock, or RE in fixed mode |
| pin_dat_mode1_i | input | 1 | Serial data, or TE in fixed mode |
| pin_en_strap0_i | input | 1 | Serial enable, or strap0 in fixed mode |
| pin_strap1_i | input | 1 | Strap1 input (fixed mode only) |
| lock_in_i | input | 1 | PLL lock indication to forward |
| lock_o | output | 1 | Lock-detect value for the shared strap1 pad |
| lock_oe_o | output | 1 | Output enable for the shared strap1 pad |
| word_a_o | output | 22 | Control word A |
| word_b_o | output | 22 | Control word B |
| word_c_o | output | 22 | Control word C |
| word_d_o | output | 22 | Control word D |
| op_mode_o | output | 2 | Operating state {TE,RE} |
| prog_mode_o | output | 1 | High once programmable mode is entered |

## Verification
The bench resets the block under all four strap pairs, which shows whether each preset channel maps to the right ratios and band bit. It then steps the mode pins through all four codes, which checks the fixed-mode state decode. Serial writes go to C and to A, and a 30-bit stream with six junk leading bits goes to D. These separate MSB-first order, the trimming to the last 24 bits and address decoding from disturbance of the other words. Two more patterns cover the entry into programmable mode: a falling strap edge, and a rising one that also writes. Strap toggles after that entry must not alter the words.

// File: rtl/cfg3w_pkg.sv
// Package: shared types and the fixed-channel preset table for the
// three-wire control port. Assumes the 22-bit word field layout.
package cfg3w_pkg;

    typedef enum logic [1:0] {
        OPM_STANDBY  = 2'b00,
        OPM_RECEIVE  = 2'b01,
        OPM_TRANSMIT = 2'b10,
        OPM_IDLE     = 2'b11
    } opmode_e;

    typedef struct packed {
        logic [9:0]  ref_div;
        logic [16:0] fb_rx;
        logic [16:0] fb_tx;
        logic        hi_band;
    } preset_t;

    // Preset for a strap pair, index = {strap1, strap0} (R5)
    function automatic preset_t preset_for(input logic [1:0] chan);
        preset_t p;
        case (chan)
            2'b00:   p = '{ref_div: 10'd16, fb_rx: 17'd1919, fb_tx: 17'd1943, hi_band: 1'b1};
            2'b01:   p = '{ref_div: 10'd16, fb_rx: 17'd947,  fb_tx: 17'd971,  hi_band: 1'b0};
            2'b10:   p = '{ref_div: 10'd30, fb_rx: 17'd3794, fb_tx: 17'd3839, hi_band: 1'b1};
            default: p = '{ref_div: 10'd18, fb_rx: 17'd766,  fb_tx: 17'd793,  hi_band: 1'b0};
        endcase
        return p;
    endfunction

endpackage

// File: rtl/cfg3w_sync.sv
// Module: multi-bit flop-chain synchronizer. Each bit is an independent
// slow pin; assumes pins are stable for longer than the chain depth.
module cfg3w_sync #(
    parameter int WIDTH  = 4,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    logic [WIDTH-1:0] stage_q [STAGES];

    // Pass each pin through the flop chain
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
        end else begin
            stage_q[0] <= async_i;
            for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
        end
    end

    assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/cfg3w_shifter.sv
// Module: serial-in shift register, MSB first. Keeps only the newest
// WIDTH bits, so older leading bits fall off the top (R1).
module cfg3w_shifter #(
    parameter int WIDTH = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             shift_en,
    input  logic             bit_in,
    output logic [WIDTH-1:0] q
);
    // Shift one bit in on each strobe
    always_ff @(posedge clk) begin
        if (!rst_n)        q <= '0;
        else if (shift_en) q <= {q[WIDTH-2:0], bit_in};
    end
endmodule

// File: rtl/cfg3w_ctrl.sv
// Module: edge detection on synchronized pins and the set-only
// programmable-mode flag. Edges are ignored until the synchronizer and
// the history flops hold real pin levels after reset.
module cfg3w_ctrl #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk_s,
    input  logic sen_s,
    output logic sclk_rise,
    output logic sen_rise,
    output logic strap0_hold,
    output logic prog_q
);
    localparam int ARM_CYC = SYNC_STAGES + 1;
    localparam int CNT_W   = $clog2(ARM_CYC + 1);

    logic [CNT_W-1:0] arm_cnt;
    logic             armed;
    logic             sclk_prev;
    logic             sen_prev;
    logic             sen_change;

    assign armed = (arm_cnt == CNT_W'(ARM_CYC));

    // Count edges after reset until pin history is valid
    always_ff @(posedge clk) begin
        if (!rst_n)      arm_cnt <= '0;
        else if (!armed) arm_cnt <= arm_cnt + 1'b1;
    end

    // Keep one cycle of history for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_prev <= 1'b0;
            sen_prev  <= 1'b0;
        end else begin
            sclk_prev <= sclk_s;
            sen_prev  <= sen_s;
        end
    end

    assign sclk_rise   = armed & sclk_s & ~sclk_prev;
    assign sen_rise    = armed & sen_s & ~sen_prev;
    assign sen_change  = armed & (sen_s ^ sen_prev);
    // Strap0 as seen before any change that is being detected (R8)
    assign strap0_hold = sen_prev;

    // Set-only mode flag, cleared only by reset (R8)
    always_ff @(posedge clk) begin
        if (!rst_n)          prog_q <= 1'b0;
        else if (sen_change) prog_q <= 1'b1;
    end
endmodule

// File: rtl/cfg3w_bank.sv
// Module: the addressed control words. In fixed mode every word is
// reloaded each cycle from its preset; a write strobe overrides the
// preset for the addressed word only (R2, R3).
module cfg3w_bank #(
    parameter int ADDR_W = 2,
    parameter int WORD_W = 22
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic                                  fixed_load,
    input  logic [(1<<ADDR_W)-1:0][WORD_W-1:0]    preset_words,
    input  logic                                  wr_stb,
    input  logic [ADDR_W-1:0]                     wr_addr,
    input  logic [WORD_W-1:0]                     wr_data,
    output logic [(1<<ADDR_W)-1:0][WORD_W-1:0]    words
);
    localparam int NUM_WORDS = 1 << ADDR_W;

    for (genvar i = 0; i < NUM_WORDS; i++) begin : g_word
        logic [WORD_W-1:0] word_q;
        logic              hit;

        assign hit = wr_stb && (wr_addr == ADDR_W'(i));

        // Write on address hit, else follow preset while in fixed mode
        always_ff @(posedge clk) begin
            if (!rst_n)          word_q <= '0;
            else if (hit)        word_q <= wr_data;
            else if (fixed_load) word_q <= preset_words[i];
        end

        assign words[i] = word_q;
    end
endmodule

// File: rtl/cfg3w_port.sv
// Module: top of the three-wire control port. Synchronizes the four
// dual-use pins, shifts serial data, decodes writes into four words and
// handles the one-way change from strapped to programmable mode.
// Assumes the host holds each pin level for at least three clocks.
module cfg3w_port
    import cfg3w_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int ADDR_W      = 2,
    parameter int WORD_W      = 22
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pin_clk_mode0_i,
    input  logic              pin_dat_mode1_i,
    input  logic              pin_en_strap0_i,
    input  logic              pin_strap1_i,
    input  logic              lock_in_i,
    output logic              lock_o,
    output logic              lock_oe_o,
    output logic [WORD_W-1:0] word_a_o,
    output logic [WORD_W-1:0] word_b_o,
    output logic [WORD_W-1:0] word_c_o,
    output logic [WORD_W-1:0] word_d_o,
    output logic [1:0]        op_mode_o,
    output logic              prog_mode_o
);
    localparam int SHIFT_W   = ADDR_W + WORD_W;
    localparam int NUM_WORDS = 1 << ADDR_W;
    localparam int MODE_LSB  = 10;
    localparam int PIN_CNT   = 4;

    logic [PIN_CNT-1:0] pins_s;
    logic re_s, te_s, sen_s, strap1_s;
    logic sclk_rise, sen_rise, strap0_hold, prog_q;
    logic [SHIFT_W-1:0] shift_q;
    logic               wr_stb;
    logic [ADDR_W-1:0]  wr_addr;
    logic [WORD_W-1:0]  wr_data;
    logic [NUM_WORDS-1:0][WORD_W-1:0] preset_words;
    logic [NUM_WORDS-1:0][WORD_W-1:0] words;
    preset_t            pre;
    opmode_e            mode_now;

    cfg3w_sync #(.WIDTH(PIN_CNT), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({pin_strap1_i, pin_en_strap0_i, pin_dat_mode1_i, pin_clk_mode0_i}),
        .sync_o  (pins_s)
    );

    assign re_s     = pins_s[0];
    assign te_s     = pins_s[1];
    assign sen_s    = pins_s[2];
    assign strap1_s = pins_s[3];

    cfg3w_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .sclk_s      (re_s),
        .sen_s       (sen_s),
        .sclk_rise   (sclk_rise),
        .sen_rise    (sen_rise),
        .strap0_hold (strap0_hold),
        .prog_q      (prog_q)
    );

    cfg3w_shifter #(.WIDTH(SHIFT_W)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (sclk_rise),
        .bit_in   (te_s),
        .q        (shift_q)
    );

    // Write decode: address in the top bits, payload below (R2)
    assign wr_stb  = sen_rise;
    assign wr_addr = shift_q[SHIFT_W-1 -: ADDR_W];
    assign wr_data = shift_q[WORD_W-1:0];

    // Build the fixed-mode preset words from straps and mode pins (R5, R6)
    always_comb begin
        pre = preset_for({strap1_s, strap0_hold});
        for (int w = 0; w < NUM_WORDS; w++) preset_words[w] = '0;
        preset_words[0] = {{(WORD_W-MODE_LSB-2){1'b0}}, te_s, re_s, pre.ref_div};
        preset_words[1] = {{(WORD_W-10){1'b0}}, pre.ref_div};
        preset_words[2] = {{(WORD_W-18){1'b0}}, pre.hi_band, pre.fb_rx};
        preset_words[NUM_WORDS-1] = {{(WORD_W-17){1'b0}}, pre.fb_tx};
    end

    cfg3w_bank #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_bank (
        .clk          (clk),
        .rst_n        (rst_n),
        .fixed_load   (!prog_q),
        .preset_words (preset_words),
        .wr_stb       (wr_stb),
        .wr_addr      (wr_addr),
        .wr_data      (wr_data),
        .words        (words)
    );

    // Operating state: pins in fixed mode, word A field afterwards (R6, R7)
    always_comb begin
        if (prog_q) mode_now = opmode_e'(words[0][MODE_LSB +: 2]);
        else        mode_now = opmode_e'({te_s, re_s});
    end

    assign word_a_o    = words[0];
    assign word_b_o    = words[1];
    assign word_c_o    = words[2];
    assign word_d_o    = words[NUM_WORDS-1];
    assign op_mode_o   = mode_now;
    assign prog_mode_o = prog_q;
    // Shared strap1 pad becomes lock output once programmable (R10)
    assign lock_oe_o   = prog_q;
    assign lock_o      = prog_q & lock_in_i;
endmodule

// File: rtl/cfg3w_port_chk.sv
// Module: assertion checker for cfg3w_port, attached by bind below.
module cfg3w_port_chk #(
    parameter int ADDR_W = 2,
    parameter int WORD_W = 22
) (
    input logic              clk,
    input logic              rst_n,
    input logic              prog_mode_o,
    input logic              lock_o,
    input logic              lock_oe_o,
    input logic [1:0]        op_mode_o,
    input logic [WORD_W-1:0] word_a_o,
    input logic [WORD_W-1:0] word_b_o,
    input logic [WORD_W-1:0] word_d_o,
    input logic              wr_stb,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [WORD_W-1:0] wr_data
);
    assert_prog_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        prog_mode_o |=> prog_mode_o);

    assert_lock_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !prog_mode_o |-> (!lock_oe_o && !lock_o));

    assert_mode_from_a_R7: assert property (@(posedge clk) disable iff (!rst_n)
        prog_mode_o |-> (op_mode_o == word_a_o[11:10]));

    assert_fixed_mirror_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!prog_mode_o && $past(!prog_mode_o) && $past(rst_n))
            |-> (word_a_o[11:10] == $past(op_mode_o)));

    assert_write_a_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(wr_stb) && ($past(wr_addr) == ADDR_W'(0)))
            |-> (word_a_o == $past(wr_data)));

    assert_write_d_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(wr_stb) && ($past(wr_addr) == ADDR_W'(3)))
            |-> (word_d_o == $past(wr_data)));

    assert_hold_b_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(prog_mode_o) && !$past(wr_stb && (wr_addr == ADDR_W'(1))))
            |-> $stable(word_b_o));
endmodule

bind cfg3w_port cfg3w_port_chk #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .prog_mode_o (prog_mode_o),
    .lock_o      (lock_o),
    .lock_oe_o   (lock_oe_o),
    .op_mode_o   (op_mode_o),
    .word_a_o    (word_a_o),
    .word_b_o    (word_b_o),
    .word_d_o    (word_d_o),
    .wr_stb      (wr_stb),
    .wr_addr     (wr_addr),
    .wr_data     (wr_data)
);

// File: tb/cfg3w_port_bench.sv
module cfg3w_port_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic p_clk = 1'b0, p_dat = 1'b0, p_en = 1'b0, p_s1 = 1'b0, lock_in = 1'b0;
    logic lock_o, lock_oe, prog;
    logic [21:0] wa, wb, wc, wd;
    logic [1:0] opm;

    int checks = 0, errors = 0, epoch = 0, quiet = 0, last_epoch = 0;
    bit done = 1'b0;

    // Behavioural model state
    logic [23:0] shreg = '0;
    logic [21:0] exp_word [4];
    logic        exp_prog = 1'b0;

    cfg3w_port u_cfg3w_port (
        .clk(clk), .rst_n(rst_n),
        .pin_clk_mode0_i(p_clk), .pin_dat_mode1_i(p_dat),
        .pin_en_strap0_i(p_en), .pin_strap1_i(p_s1), .lock_in_i(lock_in),
        .lock_o(lock_o), .lock_oe_o(lock_oe),
        .word_a_o(wa), .word_b_o(wb), .word_c_o(wc), .word_d_o(wd),
        .op_mode_o(opm), .prog_mode_o(prog)
    );

    // Preset word from the R5/R6 table
    function automatic logic [21:0] preset(int idx, logic s0, logic s1, logic te, logic re);
        int rr, nr, nt;
        logic band;
        case ({s1, s0})
            2'b01:   begin rr = 16; nr = 947;  nt = 971;  band = 1'b0; end
            2'b00:   begin rr = 16; nr = 1919; nt = 1943; band = 1'b1; end
            2'b11:   begin rr = 18; nr = 766;  nt = 793;  band = 1'b0; end
            default: begin rr = 30; nr = 3794; nt = 3839; band = 1'b1; end
        endcase
        case (idx)
            0:       return 22'(rr) | (22'(te) << 11) | (22'(re) << 10);
            1:       return 22'(rr);
            2:       return 22'(nr) | (22'(band) << 17);
            default: return 22'(nt);
        endcase
    endfunction

    function automatic logic [21:0] dut_word(int idx);
        case (idx)
            0: return wa;
            1: return wb;
            2: return wc;
            default: return wd;
        endcase
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Compare every output with the model once the pins are quiet
    task automatic compare_all();
        for (int i = 0; i < 4; i++) begin
            logic [21:0] e;
            e = exp_prog ? exp_word[i] : preset(i, p_en, p_s1, p_dat, p_clk);
            chk(exp_prog ? "R2 word (clock compare)" : "R5 word (clock compare)",
                32'(dut_word(i)), 32'(e));
        end
        chk(exp_prog ? "R7 op_mode (clock compare)" : "R6 op_mode (clock compare)",
            32'(opm), exp_prog ? 32'(exp_word[0][11:10]) : 32'({p_dat, p_clk}));
        chk("R8 prog flag (clock compare)", 32'(prog), 32'(exp_prog));
        chk("R10 lock (clock compare)", 32'({lock_oe, lock_o}),
            32'({exp_prog, exp_prog & lock_in}));
    endtask

    always @(negedge clk) begin
        if (!rst_n || epoch != last_epoch) begin
            quiet = 0;
            last_epoch = epoch;
        end else begin
            if (quiet < 4) quiet++;
            if (quiet >= 4 && !done) compare_all();
        end
    end

    // Drive all pins at once and advance the model
    task automatic drive(logic c, logic d, logic e, logic s1);
        @(negedge clk);
        if (c && !p_clk) shreg = {shreg[22:0], d};
        if (e != p_en && !exp_prog) begin
            exp_prog = 1'b1;
            for (int i = 0; i < 4; i++) exp_word[i] = preset(i, p_en, s1, d, c);
        end
        if (e && !p_en) exp_word[shreg[23:22]] = shreg[21:0];
        p_clk = c; p_dat = d; p_en = e; p_s1 = s1;
        epoch++;
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset(logic s0, logic s1, logic te, logic re);
        @(negedge clk);
        rst_n = 1'b0;
        p_en = s0; p_s1 = s1; p_dat = te; p_clk = re;
        shreg = '0; exp_prog = 1'b0;
        epoch++;
        idle(3);
        rst_n = 1'b1;
        epoch++;
        idle(8);
    endtask

    task automatic send_bits(logic [39:0] v, int n);
        for (int i = n - 1; i >= 0; i--) begin
            drive(1'b0, v[i], p_en, p_s1); idle(4);
            drive(1'b1, v[i], p_en, p_s1); idle(4);
        end
        drive(1'b0, p_dat, p_en, p_s1); idle(4);
    endtask

    task automatic pulse_en();
        drive(p_clk, p_dat, 1'b1, p_s1); idle(6);
        drive(p_clk, p_dat, 1'b0, p_s1); idle(6);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 4; i++) exp_word[i] = '0;

        // R4 R5: reset state under every strap pair
        for (int c = 0; c < 4; c++) begin
            logic s0, s1;
            s0 = c[0]; s1 = c[1];
            do_reset(s0, s1, 1'b0, 1'b0);
            chk("R4 prog after reset", 32'(prog), 0);
            chk("R4 lock pad after reset", 32'({lock_oe, lock_o}), 0);
            chk("R5 word B ref ratio", 32'(wb), 32'(preset(1, s0, s1, 1'b0, 1'b0)));
            chk("R5 word C rx ratio", 32'(wc), 32'(preset(2, s0, s1, 1'b0, 1'b0)));
            chk("R5 word D tx ratio", 32'(wd), 32'(preset(3, s0, s1, 1'b0, 1'b0)));
        end

        // R6: mode pins in fixed mode, all four codes
        for (int m = 0; m < 4; m++) begin
            drive(m[0], m[1], p_en, p_s1); idle(5);
            chk("R6 op_mode from pins", 32'(opm), 32'(m));
            chk("R6 word A mode field", 32'(wa[11:10]), 32'(m));
        end

        // R8: falling strap0 enters programmable mode, receive pins held
        do_reset(1'b1, 1'b0, 1'b0, 1'b1);
        chk("R5 433 channel C", 32'(wc), 947);
        drive(p_clk, p_dat, 1'b0, p_s1); idle(6);
        chk("R8 prog after falling strap", 32'(prog), 1);
        chk("R8 frozen preset C", 32'(wc), 947);
        chk("R7 op_mode receive from A", 32'(opm), 1);
        lock_in = 1'b1; epoch++; idle(3);
        chk("R10 lock follows input", 32'({lock_oe, lock_o}), 3);
        lock_in = 1'b0; epoch++; idle(3);
        chk("R10 lock follows low input", 32'({lock_oe, lock_o}), 2);

        // R2 R3: write word C
        send_bits({16'h0, 2'b10, 22'h2ABCDE}, 24);
        pulse_en();
        chk("R2 word C written", 32'(wc), 32'h2ABCDE);
        chk("R3 word B kept", 32'(wb), 16);
        chk("R3 word D kept", 32'(wd), 971);

        // R1: 30 bits, six leading junk bits dropped
        send_bits({10'h0, 6'b111111, 2'b11, 22'h012345}, 30);
        pulse_en();
        chk("R1 word D last 24 bits", 32'(wd), 32'h012345);
        chk("R3 word C kept", 32'(wc), 32'h2ABCDE);

        // R7: mode field written through word A
        send_bits({16'h0, 2'b00, 22'h000800}, 24);
        pulse_en();
        chk("R7 op_mode transmit", 32'(opm), 2);
        send_bits({16'h0, 2'b00, 22'h000C00}, 24);
        pulse_en();
        chk("R7 op_mode idle", 32'(opm), 3);

        // R9: strap1 and mode pins no longer matter
        drive(1'b1, 1'b1, p_en, 1'b1); idle(6);
        chk("R9 word B after strap1 change", 32'(wb), 16);
        chk("R9 word A after mode pin change", 32'(wa), 32'h000C00);
        chk("R9 prog still set", 32'(prog), 1);

        // R8: rising strap0 enters programmable mode and writes
        do_reset(1'b0, 1'b0, 1'b0, 1'b0);
        send_bits({16'h0, 2'b01, 22'h000155}, 24);
        drive(p_clk, p_dat, 1'b1, p_s1); idle(6);
        chk("R8 prog after rising strap", 32'(prog), 1);
        chk("R8 rising switch also writes B", 32'(wb), 32'h155);
        chk("R8 preset 868 C kept", 32'(wc), 32'h20000 | 1919);
        idle(5);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule